// File: doc/BRIEF.md
# Indexed Error Record Control Window

This block holds a bank of 64-bit control registers, one for each error record, and reaches them through a single access window. A select register holds the index of the record that the window addresses. Reads of the window return the selected record's control value. Writes through the window update that record on the clock edge. The same storage can also be reached through two 32-bit views, one for the lower half and one for the upper half. Each view reads and writes only its own half.

The number of records is a parameter, and the block reports it on a read-only output. A second parameter is a bitmask that marks which indices are the first record of a node. Only those indices have storage. An index can fail to reach storage in two ways: it is at or above the record count, or it is not the first record of a node. In both cases every view reads as zero and every write is discarded. Privilege checks and the meaning of the individual control bits are handled elsewhere.

Top module: `errwin_bank`

## Requirements
- R1: A cycle with `sel_wr_en` high loads `sel_wr_data` into the select register, and `sel_q` shows the new value from the next cycle on.
- R2: `win_rd_data` combinationally returns the full 64-bit record addressed by the current `sel_q`.
- R3: `win_wr_en` writes all 64 bits of `win_wr_data` into the selected record at the clock edge. Every other record keeps its value.
- R4: `lo_rd_data` equals bits [31:0] of the selected record. `lo_wr_en` replaces only those bits, with `lo_wr_data`.
- R5: `hi_rd_data` equals bits [63:32] of the selected record. `hi_wr_en` replaces only those bits, with `hi_wr_data`.
- R6: If a window write and an alias write reach the same record in the same cycle, the record takes the window value.
- R7: If `NUM_REC` is zero or `sel_q >= NUM_REC`, all three read views return zero and no write changes any record.
- R8: An in-range index whose bit in `OWNER_MASK` is 0 (bit i stands for index i; 1 means the index owns storage) reads as zero on all views and ignores writes.
- R9: Reset clears the select register and every record to zero.
- R10: `rec_count` always equals `NUM_REC`.
- R11: If the select register and a record are written in the same cycle, the record write goes to the index held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_wr_en | input | 1 | Load the select register |
| sel_wr_data | input | SEL_W | New select index |
| sel_q | output | SEL_W | Current select index |
| win_wr_en | input | 1 | Write all 64 bits of the selected record |
| win_wr_data | input | 64 | Window write value |
| win_rd_data | output | 64 | Selected record, full width |
| lo_wr_en | input | 1 | Write the lower half of the selected record |
| lo_wr_data | input | 32 | Lower-half write value |
| lo_rd_data | output | 32 | Selected record bits [31:0] |
| hi_wr_en | input | 1 | Write the upper half of the selected record |
| hi_wr_data | input | 32 | Upper-half write value |
| hi_rd_data | output | 32 | Selected record bits [63:32] |
| rec_count | output | CNT_W | Number of implemented record indices |

## Verification
The bench builds the bank with `NUM_REC` = 5, `OWNER_MASK` = 5'b11011 and a 4-bit select. Index 2 is therefore an in-range slot without storage. Select values 5 to 15 fall outside the bank, so both ways of reaching no record can be tried next to real records. The narrow select covers the whole index space, including the maximum value 15. With five records, writes to neighbouring slots can be checked for leaks into each other.

// File: rtl/errwin_pkg.sv
package errwin_pkg;
    localparam int REC_W  = 64;
    localparam int HALF_W = REC_W / 2;

    typedef logic [REC_W-1:0]  rec_t;
    typedef logic [HALF_W-1:0] half_t;

    // write request as seen by one record slot
    typedef struct packed {
        logic  win_we;
        logic  lo_we;
        logic  hi_we;
        rec_t  win_data;
        half_t lo_data;
        half_t hi_data;
    } wr_req_t;
endpackage

// File: rtl/errwin_decode.sv
module errwin_decode #(
    parameter int NUM_REC = 4,
    parameter int SEL_W   = 8,
    localparam int SLOTS  = (NUM_REC > 0) ? NUM_REC : 1
) (
    input  logic [SEL_W-1:0] sel,
    output logic [SLOTS-1:0] hit,
    output logic             in_range
);
    // an index in range of an empty bank never exists
    assign in_range = (NUM_REC > 0) && (32'(sel) < NUM_REC);

    for (genvar i = 0; i < SLOTS; i++) begin : g_hit
        assign hit[i] = in_range && (32'(sel) == i);
    end
endmodule

// File: rtl/errwin_record.sv
module errwin_record
    import errwin_pkg::*;
#(
    parameter bit OWNED = 1'b1
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    sel_hit,
    input  wr_req_t req,
    output rec_t    value
);
    if (OWNED) begin : g_store
        rec_t val_d, val_q;

        always_comb begin
            val_d = val_q;
            if (sel_hit) begin
                if (req.lo_we) val_d[HALF_W-1:0]     = req.lo_data;
                if (req.hi_we) val_d[REC_W-1:HALF_W] = req.hi_data;
                // full window write wins over the half views
                if (req.win_we) val_d = req.win_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) val_q <= '0;
            else        val_q <= val_d;
        end

        assign value = val_q;

        // R6: window value wins over any half write
        a_r6_window_priority: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_hit && req.win_we) |=> (val_q == $past(req.win_data)));
        // R4/R5: half writes alone keep the other half
        a_r4_lo_keeps_hi: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_hit && req.lo_we && !req.hi_we && !req.win_we)
            |=> (val_q[REC_W-1:HALF_W] == $past(val_q[REC_W-1:HALF_W])));
        a_r5_hi_keeps_lo: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_hit && req.hi_we && !req.lo_we && !req.win_we)
            |=> (val_q[HALF_W-1:0] == $past(val_q[HALF_W-1:0])));
    end else begin : g_absent
        logic unused_ok;
        assign unused_ok = ^{clk, rst_n, sel_hit, req};
        assign value = '0;
    end
endmodule

// File: rtl/errwin_bank.sv
module errwin_bank
    import errwin_pkg::*;
#(
    parameter int          NUM_REC    = 4,
    parameter logic [63:0] OWNER_MASK = '1,
    parameter int          SEL_W      = 8,
    parameter int          CNT_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_wr_en,
    input  logic [SEL_W-1:0] sel_wr_data,
    output logic [SEL_W-1:0] sel_q,
    input  logic             win_wr_en,
    input  logic [63:0]      win_wr_data,
    output logic [63:0]      win_rd_data,
    input  logic             lo_wr_en,
    input  logic [31:0]      lo_wr_data,
    output logic [31:0]      lo_rd_data,
    input  logic             hi_wr_en,
    input  logic [31:0]      hi_wr_data,
    output logic [31:0]      hi_rd_data,
    output logic [CNT_W-1:0] rec_count
);
    localparam int SLOTS = (NUM_REC > 0) ? NUM_REC : 1;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (sel_wr_en) ctl_d.sel = sel_wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign sel_q = ctl_q.sel;

    logic [SLOTS-1:0] hit;
    logic             in_range;

    errwin_decode #(.NUM_REC(NUM_REC), .SEL_W(SEL_W)) u_dec (
        .sel      (ctl_q.sel),
        .hit      (hit),
        .in_range (in_range)
    );

    wr_req_t req;
    assign req.win_we   = win_wr_en;
    assign req.lo_we    = lo_wr_en;
    assign req.hi_we    = hi_wr_en;
    assign req.win_data = win_wr_data;
    assign req.lo_data  = lo_wr_data;
    assign req.hi_data  = hi_wr_data;

    rec_t slot_val [SLOTS];

    for (genvar i = 0; i < SLOTS; i++) begin : g_rec
        errwin_record #(.OWNED((NUM_REC > 0) && OWNER_MASK[i])) u_rec (
            .clk     (clk),
            .rst_n   (rst_n),
            .sel_hit (hit[i]),
            .req     (req),
            .value   (slot_val[i])
        );
    end

    rec_t rd_val;
    always_comb begin
        rd_val = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (hit[i]) rd_val = rd_val | slot_val[i];
        end
    end

    assign win_rd_data = rd_val;
    assign lo_rd_data  = rd_val[HALF_W-1:0];
    assign hi_rd_data  = rd_val[REC_W-1:HALF_W];
    assign rec_count   = CNT_W'(NUM_REC);

    logic [63:0] own_shift;
    assign own_shift = OWNER_MASK >> ctl_q.sel;

    // R1: select load visible next cycle
    a_r1_select_load: assert property (@(posedge clk) disable iff (!rst_n)
        sel_wr_en |=> (sel_q == $past(sel_wr_data)));
    // R7: out-of-range index reads zero
    a_r7_oor_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !in_range |-> (win_rd_data == '0));
    // R8: index without storage reads zero
    a_r8_absent_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_range && !own_shift[0]) |-> (win_rd_data == '0));
    // R3: full write lands in selected record when the select holds
    a_r3_window_write: assert property (@(posedge clk) disable iff (!rst_n)
        (win_wr_en && in_range && own_shift[0] && !sel_wr_en)
        |=> (win_rd_data == $past(win_wr_data)));
endmodule

// File: tb/errwin_bank_test.sv
module errwin_bank_test;
    localparam int CLK_PERIOD = 10;
    localparam int NREC = 5;
    localparam int SW   = 4;
    localparam int NVEC = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel_wr_en = 1'b0;
    logic [SW-1:0] sel_wr_data = '0;
    logic [SW-1:0] sel_q;
    logic          win_wr_en = 1'b0;
    logic [63:0]   win_wr_data = '0;
    logic [63:0]   win_rd_data;
    logic          lo_wr_en = 1'b0;
    logic [31:0]   lo_wr_data = '0;
    logic [31:0]   lo_rd_data;
    logic          hi_wr_en = 1'b0;
    logic [31:0]   hi_wr_data = '0;
    logic [31:0]   hi_rd_data;
    logic [15:0]   rec_count;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    errwin_bank #(.NUM_REC(NREC), .OWNER_MASK(64'b11011), .SEL_W(SW), .CNT_W(16)) uut (
        .clk(clk), .rst_n(rst_n),
        .sel_wr_en(sel_wr_en), .sel_wr_data(sel_wr_data), .sel_q(sel_q),
        .win_wr_en(win_wr_en), .win_wr_data(win_wr_data), .win_rd_data(win_rd_data),
        .lo_wr_en(lo_wr_en), .lo_wr_data(lo_wr_data), .lo_rd_data(lo_rd_data),
        .hi_wr_en(hi_wr_en), .hi_wr_data(hi_wr_data), .hi_rd_data(hi_rd_data),
        .rec_count(rec_count)
    );

    typedef struct packed {
        logic [SW-1:0] sel;
        logic          w;
        logic          l;
        logic          h;
        logic [63:0]   wd;
        logic [31:0]   ad;
        logic [63:0]   exp;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{4'd0,  1'b1, 1'b0, 1'b0, 64'h1111_2222_3333_4444, 32'h0, 64'h1111_2222_3333_4444}, // R3
        '{4'd1,  1'b0, 1'b1, 1'b0, 64'h0, 32'hAAAA_BBBB, 64'h0000_0000_AAAA_BBBB},          // R4
        '{4'd1,  1'b0, 1'b0, 1'b1, 64'h0, 32'hCCCC_DDDD, 64'hCCCC_DDDD_AAAA_BBBB},          // R5
        '{4'd2,  1'b1, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 32'hFFFF_FFFF, 64'h0},          // R8
        '{4'd7,  1'b1, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 32'h0, 64'h0},                  // R7
        '{4'd0,  1'b0, 1'b0, 1'b0, 64'h0, 32'h0, 64'h1111_2222_3333_4444},                  // R7 no leak
        '{4'd3,  1'b1, 1'b1, 1'b0, 64'h5555_6666_7777_8888, 32'h0, 64'h5555_6666_7777_8888}, // R6
        '{4'd4,  1'b0, 1'b1, 1'b1, 64'h0, 32'h1234_5678, 64'h1234_5678_1234_5678},          // R4 R5
        '{4'd1,  1'b0, 1'b0, 1'b0, 64'h0, 32'h0, 64'hCCCC_DDDD_AAAA_BBBB},                  // R2
        '{4'd15, 1'b0, 1'b1, 1'b1, 64'h0, 32'h9999_9999, 64'h0},                            // R7 max index
        '{4'd3,  1'b0, 1'b0, 1'b0, 64'h0, 32'h0, 64'h5555_6666_7777_8888}                   // R3 R2
    };

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_views(input string tag, input logic [63:0] exp);
        chk(win_rd_data == exp && lo_rd_data == exp[31:0] && hi_rd_data == exp[63:32],
            tag, {hi_rd_data, lo_rd_data} ^ (win_rd_data ^ win_rd_data), exp);
        if (win_rd_data != {hi_rd_data, lo_rd_data})
            chk(1'b0, {tag, " window"}, win_rd_data, exp);
    endtask

    task automatic select(input logic [SW-1:0] s);
        @(negedge clk);
        sel_wr_en = 1'b1; sel_wr_data = s;
        @(negedge clk);
        sel_wr_en = 1'b0;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 5000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 / R10: reset state
        chk(sel_q == '0, "R9 select after reset", 64'(sel_q), 64'h0);
        chk_views("R9 record 0 after reset", 64'h0);
        chk(rec_count == 16'(NREC), "R10 record count", 64'(rec_count), 64'(NREC));
        rst_n = 1'b1;
        @(negedge clk);

        // R1: select load
        select(4'd9);
        chk(sel_q == 4'd9, "R1 select load", 64'(sel_q), 64'd9);

        foreach (VECS[i]) begin
            select(VECS[i].sel);
            win_wr_en  = VECS[i].w;
            lo_wr_en   = VECS[i].l;
            hi_wr_en   = VECS[i].h;
            win_wr_data = VECS[i].wd;
            lo_wr_data  = VECS[i].ad;
            hi_wr_data  = VECS[i].ad;
            @(negedge clk);
            win_wr_en = 1'b0; lo_wr_en = 1'b0; hi_wr_en = 1'b0;
            chk_views($sformatf("R2 vector %0d", i), VECS[i].exp);
        end

        // R11: select and record write in the same cycle (sel_q is 3 here)
        @(negedge clk);
        sel_wr_en = 1'b1; sel_wr_data = 4'd0;
        win_wr_en = 1'b1; win_wr_data = 64'hDEAD_BEEF_0BAD_F00D;
        @(negedge clk);
        sel_wr_en = 1'b0; win_wr_en = 1'b0;
        chk(sel_q == 4'd0, "R11 select moved", 64'(sel_q), 64'h0);
        chk_views("R11 record 0 untouched", 64'h1111_2222_3333_4444);
        select(4'd3);
        chk_views("R11 record 3 took write", 64'hDEAD_BEEF_0BAD_F00D);

        // R8: non-owner slot still reads zero after writes
        select(4'd2);
        chk_views("R8 absent slot", 64'h0);

        // R9: reset mid-run clears records and select
        select(4'd4);
        rst_n = 1'b0;
        @(negedge clk);
        chk(sel_q == '0, "R9 select cleared", 64'(sel_q), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_views("R9 record 0 cleared", 64'h0);
        select(4'd4);
        chk_views("R9 record 4 cleared", 64'h0);
        chk(rec_count == 16'(NREC), "R10 record count stable", 64'(rec_count), 64'(NREC));

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule